// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture Queue

This block takes inbound message-signalled interrupt writes, each carrying one 32-bit data word, and records every accepted message as a 16-byte entry in a circular queue in system memory. For each message it issues one write on a memory master port, addressed at the queue base plus the current write offset. Once that write has been acknowledged, the write offset moves forward by one entry. Software consumes entries by moving the read offset forward. An interrupt line stays high while unconsumed entries remain.

A small word-addressed register port holds the control word, the 64-bit queue base (split into a high and a low word), and the read and write offsets. The queue size is a power of two from 32 KB to 256 KB. A control code selects it. Two policies apply when the queue fills. In the stopping policy, incoming messages are held off. In the overwriting policy, the oldest entry is dropped and a sticky overflow flag is set.

Top module: `msi_ring_ctrl`

## Requirements
- R1: The register word addresses are: control 0, base high 3, base low 4, read offset 5, write offset 6. Control fields are: bit 0 run, bit 1 full detection, bit 3 interrupt enable, bit 4 stop-when-full, bits 9:8 size code, bit 15 overflow. All other control bits read as zero.
- R2: A message is accepted (msg_ready high) only while run is set and the block is not busy. Each accepted message produces one memory write to address {base_hi, base_lo} + write offset. The data is 128 bits: the message word sits in bits 31:0, so byte 0 is bits 7:0, and the remaining bits are zero.
- R3: mem_valid, with a stable address, is held until mem_ready is seen. The write offset changes only in the cycle after that acknowledge, and then by exactly 16.
- R4: The offsets wrap modulo the queue size 2^(code+15) bytes. A write at offset size-16 is followed by offset 0.
- R5: A write to the read offset ignores the low 4 bits and every bit at or above the queue size.
- R6: A read of the write offset is always masked to the current queue size, including after the size is reduced.
- R7: irq is high exactly when run and interrupt enable are both set and the read offset differs from the write offset.
- R8: When full detection and stop are both set and (write offset + 16) mod size equals the read offset, msg_ready stays low until software frees a slot.
- R9: When full detection is set, stop is clear and the queue is full at the acknowledge, the entry is still written. The read offset then advances by 16, dropping the oldest entry, and bit 15 is set. Bit 15 stays set through control writes and clears only when a control write has bit 15 = 1.
- R10: With full detection clear, a write into a full queue changes neither the read offset nor bit 15.
- R11: If a software write to the read offset lands in the same cycle as an overflowing acknowledge, the software value is kept. The overflow flag is still set.
- R12: After reset, every register reads zero, irq is low and no memory write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| msg_valid | input | 1 | Inbound message present |
| msg_data | input | 32 | Inbound message data word |
| msg_ready | output | 1 | Message accepted this cycle |
| mem_valid | output | 1 | Memory write request |
| mem_addr | output | 64 | Memory write byte address |
| mem_data | output | 128 | Queue entry contents |
| mem_ready | input | 1 | Memory write acknowledge |
| irq | output | 1 | Unconsumed entries present |

## Verification
The entry acknowledge and a software move of the read offset can fall on the same clock edge. This matters because the acknowledge may also want to drop the oldest entry and advance that same read offset. The bench holds the memory acknowledge low while an entry is pending against a full queue. It then raises the acknowledge and strobes a read-offset write on the same falling edge, so both take effect at one rising edge. The result is judged from the register port: the read offset must show the software value, the write offset must have advanced by one entry, and the overflow flag must be set.

// File: rtl/msi_ring_pkg.sv
package msi_ring_pkg;

    localparam int RING_OFFS_W  = 18;
    localparam int RING_CODE_W  = 2;
    localparam int RING_MIN_SH  = 15;
    localparam int RING_ENTRY_B = 16;

    // register word addresses
    localparam logic [2:0] REG_CTRL    = 3'd0;
    localparam logic [2:0] REG_BASE_HI = 3'd3;
    localparam logic [2:0] REG_BASE_LO = 3'd4;
    localparam logic [2:0] REG_RD_OFS  = 3'd5;
    localparam logic [2:0] REG_WR_OFS  = 3'd6;

    // control bit positions
    localparam int CB_RUN   = 0;
    localparam int CB_FULL  = 1;
    localparam int CB_IRQ   = 3;
    localparam int CB_STOP  = 4;
    localparam int CB_SIZE  = 8;
    localparam int CB_OVF   = 15;

    typedef struct packed {
        logic                   ovf;
        logic [RING_CODE_W-1:0] size;
        logic                   stop_en;
        logic                   irq_en;
        logic                   full_en;
        logic                   run;
    } ctrl_t;

    typedef enum logic {ENG_IDLE, ENG_WRITE} eng_state_e;

endpackage

// File: rtl/msi_ring_size_dec.sv
module msi_ring_size_dec #(
    parameter int OFFS_W      = 18,
    parameter int CODE_W      = 2,
    parameter int MIN_SHIFT   = 15,
    parameter int ENTRY_SHIFT = 4
) (
    input  logic [CODE_W-1:0] code,
    output logic [OFFS_W-1:0] mask
);
    localparam int N_CODES = 1 << CODE_W;
    localparam logic [OFFS_W-1:0] LOW_CLR = ~OFFS_W'((64'd1 << ENTRY_SHIFT) - 64'd1);

    logic [OFFS_W-1:0] per_code [N_CODES];

    genvar g;
    generate
        for (g = 0; g < N_CODES; g++) begin : g_code
            localparam int SHIFT = MIN_SHIFT + g;
            assign per_code[g] = OFFS_W'((64'd1 << SHIFT) - 64'd1) & LOW_CLR;
        end
    endgenerate

    assign mask = per_code[code];
endmodule

// File: rtl/msi_ring_ptr_math.sv
module msi_ring_ptr_math #(
    parameter int OFFS_W      = 18,
    parameter int ENTRY_BYTES = 16
) (
    input  logic [OFFS_W-1:0] wr,
    input  logic [OFFS_W-1:0] rd,
    input  logic [OFFS_W-1:0] mask,
    output logic [OFFS_W-1:0] wr_cur,
    output logic [OFFS_W-1:0] wr_nxt,
    output logic [OFFS_W-1:0] rd_nxt,
    output logic              empty,
    output logic              full
);
    localparam logic [OFFS_W-1:0] STEP = OFFS_W'(ENTRY_BYTES);

    logic [OFFS_W-1:0] rd_cur;

    always_comb begin
        wr_cur = wr & mask;
        rd_cur = rd & mask;
        wr_nxt = (wr_cur + STEP) & mask;
        rd_nxt = (rd_cur + STEP) & mask;
        empty  = (wr_cur == rd_cur);
        full   = (wr_nxt == rd_cur);
    end
endmodule

// File: rtl/msi_ring_wr_eng.sv
module msi_ring_wr_eng
    import msi_ring_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 32,
    parameter int OFFS_W = 18,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_ok,
    input  logic              msg_valid,
    input  logic [DATA_W-1:0] msg_data,
    output logic              msg_ready,
    input  logic [ADDR_W-1:0] base,
    input  logic [OFFS_W-1:0] wr_cur,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_data,
    input  logic              mem_ready,
    output logic              done
);
    typedef struct packed {
        eng_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d     = eng_q;
        done      = 1'b0;
        msg_ready = (eng_q.state == ENG_IDLE) && accept_ok;
        case (eng_q.state)
            ENG_IDLE: begin
                if (msg_valid && msg_ready) begin
                    eng_d.state = ENG_WRITE;
                    eng_d.addr  = base + ADDR_W'(wr_cur);
                    eng_d.data  = msg_data;
                end
            end
            ENG_WRITE: begin
                if (mem_ready) begin
                    done        = 1'b1;
                    eng_d.state = ENG_IDLE;
                end
            end
            default: eng_d.state = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign mem_valid = (eng_q.state == ENG_WRITE);
    assign mem_addr  = eng_q.addr;
    assign mem_data  = LINE_W'(eng_q.data);
endmodule

// File: rtl/msi_ring_ctrl.sv
module msi_ring_ctrl
    import msi_ring_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int DATA_W    = 32,
    parameter int REG_AW    = 3,
    parameter int REG_DW    = 32,
    parameter int OFFS_W    = RING_OFFS_W,
    parameter int CODE_W    = RING_CODE_W,
    parameter int MIN_SHIFT = RING_MIN_SH,
    parameter int LINE_W    = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              msg_valid,
    input  logic [DATA_W-1:0] msg_data,
    output logic              msg_ready,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_data,
    input  logic              mem_ready,
    output logic              irq
);
    localparam int ENTRY_SHIFT = $clog2(RING_ENTRY_B);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [REG_DW-1:0] base_hi;
        logic [REG_DW-1:0] base_lo;
        logic [OFFS_W-1:0] rd;
        logic [OFFS_W-1:0] wr;
    } ring_t;

    ring_t ring_d, ring_q;

    logic [OFFS_W-1:0] size_mask;
    logic [OFFS_W-1:0] wr_cur, wr_nxt, rd_nxt;
    logic              q_empty, q_full;
    logic              accept_ok, eng_done, sw_rd_wr;
    logic [ADDR_W-1:0] base_addr;

    // plain views for the bound checker
    logic              ctrl_run, ctrl_ovf;
    logic [OFFS_W-1:0] rd_ofs_q, wr_ofs_q;
    logic              unused_wdata;

    msi_ring_size_dec #(
        .OFFS_W(OFFS_W), .CODE_W(CODE_W),
        .MIN_SHIFT(MIN_SHIFT), .ENTRY_SHIFT(ENTRY_SHIFT)
    ) u_size (
        .code(ring_q.ctrl.size),
        .mask(size_mask)
    );

    msi_ring_ptr_math #(
        .OFFS_W(OFFS_W), .ENTRY_BYTES(RING_ENTRY_B)
    ) u_ptr (
        .wr(ring_q.wr), .rd(ring_q.rd), .mask(size_mask),
        .wr_cur(wr_cur), .wr_nxt(wr_nxt), .rd_nxt(rd_nxt),
        .empty(q_empty), .full(q_full)
    );

    assign base_addr = ADDR_W'({ring_q.base_hi, ring_q.base_lo});
    assign accept_ok = ring_q.ctrl.run &&
                       !(ring_q.ctrl.full_en && ring_q.ctrl.stop_en && q_full);

    msi_ring_wr_eng #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFS_W(OFFS_W), .LINE_W(LINE_W)
    ) u_eng (
        .clk(clk), .rst_n(rst_n),
        .accept_ok(accept_ok),
        .msg_valid(msg_valid), .msg_data(msg_data), .msg_ready(msg_ready),
        .base(base_addr), .wr_cur(wr_cur),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_ready(mem_ready),
        .done(eng_done)
    );

    assign sw_rd_wr = reg_we && (reg_addr == REG_AW'(REG_RD_OFS));

    always_comb begin
        ring_d = ring_q;
        if (reg_we) begin
            if (reg_addr == REG_AW'(REG_CTRL)) begin
                ring_d.ctrl.run     = reg_wdata[CB_RUN];
                ring_d.ctrl.full_en = reg_wdata[CB_FULL];
                ring_d.ctrl.irq_en  = reg_wdata[CB_IRQ];
                ring_d.ctrl.stop_en = reg_wdata[CB_STOP];
                ring_d.ctrl.size    = reg_wdata[CB_SIZE +: CODE_W];
                if (reg_wdata[CB_OVF]) ring_d.ctrl.ovf = 1'b0;
            end else if (reg_addr == REG_AW'(REG_BASE_HI)) begin
                ring_d.base_hi = reg_wdata;
            end else if (reg_addr == REG_AW'(REG_BASE_LO)) begin
                ring_d.base_lo = reg_wdata;
            end else if (sw_rd_wr) begin
                ring_d.rd = reg_wdata[OFFS_W-1:0] & size_mask;
            end
        end
        // entry landed in memory: publish it, drop oldest on overflow
        if (eng_done) begin
            ring_d.wr = wr_nxt;
            if (ring_q.ctrl.full_en && q_full) begin
                ring_d.ctrl.ovf = 1'b1;
                if (!sw_rd_wr) ring_d.rd = rd_nxt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ring_q <= '0;
        else        ring_q <= ring_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_AW'(REG_CTRL)) begin
            reg_rdata[CB_RUN]            = ring_q.ctrl.run;
            reg_rdata[CB_FULL]           = ring_q.ctrl.full_en;
            reg_rdata[CB_IRQ]            = ring_q.ctrl.irq_en;
            reg_rdata[CB_STOP]           = ring_q.ctrl.stop_en;
            reg_rdata[CB_SIZE +: CODE_W] = ring_q.ctrl.size;
            reg_rdata[CB_OVF]            = ring_q.ctrl.ovf;
        end else if (reg_addr == REG_AW'(REG_BASE_HI)) begin
            reg_rdata = ring_q.base_hi;
        end else if (reg_addr == REG_AW'(REG_BASE_LO)) begin
            reg_rdata = ring_q.base_lo;
        end else if (reg_addr == REG_AW'(REG_RD_OFS)) begin
            reg_rdata = REG_DW'(ring_q.rd);
        end else if (reg_addr == REG_AW'(REG_WR_OFS)) begin
            reg_rdata = REG_DW'(wr_cur);
        end
    end

    assign irq = ring_q.ctrl.run && ring_q.ctrl.irq_en && !q_empty;

    assign ctrl_run     = ring_q.ctrl.run;
    assign ctrl_ovf     = ring_q.ctrl.ovf;
    assign rd_ofs_q     = ring_q.rd;
    assign wr_ofs_q     = ring_q.wr;
    assign unused_wdata = ^reg_wdata;
endmodule

// File: rtl/msi_ring_chk.sv
module msi_ring_chk #(
    parameter int ADDR_W = 64,
    parameter int OFFS_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              msg_ready,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              irq,
    input logic              reg_we,
    input logic              ovf_clr_req,
    input logic              ctrl_run,
    input logic              ctrl_ovf,
    input logic [OFFS_W-1:0] rd_ofs_q,
    input logic [OFFS_W-1:0] wr_ofs_q
);
    // R2
    no_accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_run |-> !msg_ready);

    // R3
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr));

    // R3
    wr_only_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_valid && mem_ready) |=> $stable(wr_ofs_q));

    // R5
    rd_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ofs_q[3:0] == 4'd0);

    // R7
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(mem_valid && mem_ready) || $past(reg_we));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_ovf && !ovf_clr_req |=> ctrl_ovf);
endmodule

bind msi_ring_ctrl msi_ring_chk #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .msg_ready(msg_ready), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .irq(irq), .reg_we(reg_we),
    .ovf_clr_req(reg_we && (reg_addr == 3'd0) && reg_wdata[15]),
    .ctrl_run(ctrl_run), .ctrl_ovf(ctrl_ovf),
    .rd_ofs_q(rd_ofs_q), .wr_ofs_q(wr_ofs_q)
);

// File: tb/msi_ring_ctrl_tb.sv
`timescale 1ns/1ps
module msi_ring_ctrl_tb;
    localparam logic [63:0] BASE = 64'h0000_0001_0004_0000;
    localparam int NV = 4;
    // {message word, write offset after the entry}
    localparam logic [49:0] VEC [NV] = '{
        {32'hA5A5_0001, 18'h00010},
        {32'h0000_FFFF, 18'h00020},
        {32'h1234_0042, 18'h00030},
        {32'h8000_0000, 18'h00040}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         msg_valid = 1'b0;
    logic [31:0]  msg_data = '0;
    logic         msg_ready;
    logic         mem_valid;
    logic [63:0]  mem_addr;
    logic [127:0] mem_data;
    logic         mem_ready = 1'b1;
    logic         irq;

    int           n_chk = 0;
    int           n_bad = 0;
    int           cap_cnt = 0;
    logic [63:0]  cap_addr = '0;
    logic [127:0] cap_data = '0;
    logic [31:0]  rv;
    int           base_cnt;

    always #4 clk = ~clk;

    msi_ring_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .msg_valid(msg_valid), .msg_data(msg_data), .msg_ready(msg_ready),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_ready(mem_ready), .irq(irq)
    );

    // memory model: records each acknowledged entry
    always @(posedge clk) begin
        if (rst_n && mem_valid && mem_ready) begin
            cap_cnt  <= cap_cnt + 1;
            cap_addr <= mem_addr;
            cap_data <= mem_data;
        end
    end

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic offer_msg(input logic [31:0] d);
        @(negedge clk);
        msg_valid = 1'b1; msg_data = d;
        while (!msg_ready) @(negedge clk);
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic send_msg(input logic [31:0] d);
        int old;
        old = cap_cnt;
        offer_msg(d);
        while (cap_cnt == old) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        reg_read(3'd0, rv); chk("R12 ctrl", rv, 0);
        reg_read(3'd5, rv); chk("R12 rd", rv, 0);
        reg_read(3'd6, rv); chk("R12 wr", rv, 0);
        chk("R12 irq", irq, 0);
        chk("R12 mem_valid", mem_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 field positions and reserved bits
        reg_write(3'd0, 32'hFFFF_7FFF);
        reg_read(3'd0, rv); chk("R1 ctrl fields", rv, 32'h0000_031B);
        reg_write(3'd3, BASE[63:32]);
        reg_write(3'd4, BASE[31:0]);
        reg_read(3'd3, rv); chk("R1 base hi", rv, BASE[63:32]);
        reg_read(3'd4, rv); chk("R1 base lo", rv, BASE[31:0]);
        reg_write(3'd0, 32'h0000_0109);

        // R2 vector table: entry address, layout, offset advance
        for (int i = 0; i < NV; i++) begin
            send_msg(VEC[i][49:18]);
            chk("R2 addr", cap_addr, BASE + 64'(VEC[i][17:0]) - 64'h10);
            chk("R2 data", cap_data, {96'd0, VEC[i][49:18]});
            reg_read(3'd6, rv); chk("R3 wr step", rv, 32'(VEC[i][17:0]));
            chk("R7 irq pending", irq, 1);
        end

        // R5 read offset masking
        reg_write(3'd5, 32'h0001_0035);
        reg_read(3'd5, rv); chk("R5 rd masked", rv, 32'h30);
        chk("R7 irq nonempty", irq, 1);
        reg_write(3'd5, 32'h40);
        chk("R7 irq empty", irq, 0);

        // R7 interrupt enable gating
        reg_write(3'd0, 32'h0000_0101);
        send_msg(32'h0000_0005);
        chk("R7 irq disabled", irq, 0);
        reg_write(3'd0, 32'h0000_0109);
        chk("R7 irq reenabled", irq, 1);
        reg_write(3'd5, 32'h50);

        // R3 memory back-pressure
        mem_ready = 1'b0;
        offer_msg(32'h0000_0006);
        repeat (5) @(negedge clk);
        reg_read(3'd6, rv); chk("R3 wr held", rv, 32'h50);
        chk("R3 valid held", mem_valid, 1);
        chk("R3 irq held", irq, 0);
        base_cnt = cap_cnt;
        mem_ready = 1'b1;
        while (cap_cnt == base_cnt) @(negedge clk);
        reg_read(3'd6, rv); chk("R3 wr after ack", rv, 32'h60);

        // R11 software read write vs overflowing ack in one edge
        reg_write(3'd0, 32'h0000_010B);
        reg_write(3'd5, 32'h70);
        mem_ready = 1'b0;
        offer_msg(32'h0000_0007);
        reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h20; mem_ready = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        reg_read(3'd5, rv); chk("R11 sw rd kept", rv, 32'h20);
        reg_read(3'd6, rv); chk("R11 wr advanced", rv, 32'h70);
        reg_read(3'd0, rv); chk("R11 ovf set", rv[15], 1);
        reg_write(3'd0, 32'h0000_810B);
        reg_read(3'd0, rv); chk("R9 ovf cleared", rv[15], 0);

        // R9 overwrite drops oldest
        reg_write(3'd5, 32'h80);
        send_msg(32'h0000_0008);
        reg_read(3'd5, rv); chk("R9 rd dropped", rv, 32'h90);
        reg_read(3'd6, rv); chk("R9 wr", rv, 32'h80);
        reg_read(3'd0, rv); chk("R9 ovf set", rv[15], 1);

        // R8 stop when full (control write keeps sticky flag)
        reg_write(3'd0, 32'h0000_011B);
        reg_read(3'd0, rv); chk("R9 ovf sticky", rv[15], 1);
        base_cnt = cap_cnt;
        @(negedge clk);
        msg_valid = 1'b1; msg_data = 32'h0000_0009;
        repeat (6) @(negedge clk);
        chk("R8 ready low", msg_ready, 0);
        chk("R8 no write", cap_cnt, base_cnt);
        reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 32'hA0;
        @(negedge clk);
        reg_we = 1'b0;
        while (!msg_ready) @(negedge clk);
        @(negedge clk);
        msg_valid = 1'b0;
        while (cap_cnt == base_cnt) @(negedge clk);
        reg_read(3'd6, rv); chk("R8 accepted after free", rv, 32'h90);

        // R10 full detection off
        reg_write(3'd0, 32'h0000_8109);
        send_msg(32'h0000_000A);
        reg_read(3'd5, rv); chk("R10 rd unchanged", rv, 32'hA0);
        reg_read(3'd0, rv); chk("R10 no ovf", rv[15], 0);
        chk("R10 irq", irq, 0);

        // R6 masked write offset after shrinking the queue
        for (int k = 0; k < 2039; k++) send_msg(32'(k));
        reg_read(3'd6, rv); chk("R4 wr 64KB", rv, 32'h8010);
        reg_write(3'd0, 32'h0000_0009);
        reg_read(3'd6, rv); chk("R6 wr masked", rv, 32'h10);
        send_msg(32'h0000_0BEE);
        chk("R6 addr masked", cap_addr, BASE + 64'h10);

        // R4 wrap at 32 KB
        for (int k = 0; k < 2045; k++) send_msg(32'(k));
        reg_read(3'd6, rv); chk("R4 wr last slot", rv, 32'h7FF0);
        send_msg(32'h0000_0C0D);
        chk("R4 last addr", cap_addr, BASE + 64'h7FF0);
        reg_read(3'd6, rv); chk("R4 wr wrapped", rv, 32'h0);

        // R2 no acceptance while stopped
        reg_write(3'd0, 32'h0);
        base_cnt = cap_cnt;
        @(negedge clk);
        msg_valid = 1'b1; msg_data = 32'h0000_00FF;
        repeat (5) @(negedge clk);
        chk("R2 ready off", msg_ready, 0);
        chk("R2 no write off", cap_cnt, base_cnt);
        chk("R7 irq off", irq, 0);
        msg_valid = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule